// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a 4-bit binary-coded decimal digit into the seven active-high segment drives of a single numeric display. A code holding register sits in front of the decoder. While the hold control is low, the register follows the digit input. While hold is high, the register keeps the last code it captured. Codes 10 to 15 produce a dark display, so driving such a code is another way to turn the digit off.

Two active-low controls act on the decoded pattern. The test control lights every segment so that a display can be checked for dead segments. The blank control turns every segment off. The test control has the higher priority. A brightness modulator can also force blanking on part of each 256-cycle period. It compares a free-running counter against a duty setting, so average brightness scales with that setting. The segment outputs are registered: each output reflects the inputs sampled at the previous clock edge.

Top module: `seg7_latch_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the segments, the held code and the modulation counter are all cleared to 0. A display that is held right after reset shows digit 0.
- R2: With `hold` low, `blank_n` and `test_n` high and `pwm_en` low, `seg` shows the decimal digit `digit` one clock edge after it is sampled. Bit `digit[0]` has weight 1 and `digit[3]` has weight 8. Segment a is `seg[0]`, b is `seg[1]`, c is `seg[2]`, d is `seg[3]`, e is `seg[4]`, f is `seg[5]` and g is `seg[6]`. The patterns are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 7=7'h07 and 8=7'h7F.
- R3: Digit 6 is drawn without the top segment a (7'h7C), and digit 9 is drawn without the bottom segment d (7'h67).
- R4: Codes 10 through 15 give `seg` = 7'h00.
- R5: While `hold` is low, the code register loads `digit` on every clock edge. Successive codes therefore appear on `seg` edge by edge, with no extra delay.
- R6: While `hold` is high, the decoder uses the code sampled at the last edge at which `hold` was low. Changes on `digit` during that time have no effect on `seg`.
- R7: `blank_n` low forces `seg` to 7'h00 at the next edge, whatever the code is, unless `test_n` is low.
- R8: `test_n` low forces `seg` to 7'h7F at the next edge. It overrides blanking, codes 10 to 15, the held code and the modulator.
- R9: The modulation counter is 8 bits wide and counts up by one at every edge after reset, wrapping from 255 to 0. With `pwm_en` high, segments are forced off in every cycle in which the counter is at or above `duty`. Over any 256 consecutive cycles, a lit digit shows for exactly `duty` cycles. With `pwm_en` low, the modulator has no effect.
- R10: With `pwm_en` high and `duty` = 0, the display stays dark in every cycle unless `test_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | High keeps the stored code; low lets the digit through |
| blank_n | input | 1 | Active-low display blanking |
| test_n | input | 1 | Active-low segment test, lights all segments |
| pwm_en | input | 1 | Enables the brightness modulator |
| duty | input | 8 | Lit cycles per 256-cycle modulation period |
| digit | input | 4 | BCD code, bit 0 least significant |
| seg | output | 7 | Segment drives a..g, active high, registered |

## Verification
The bench targets the edge at which `hold` rises. At that edge the decoder must keep the code taken one cycle earlier; a design that captured the current digit would show that digit instead. It also probes codes 10 to 15 and the asymmetric glyphs of 6 and 9. A decoder built from a different segment table would light a stray segment, or drop one, on exactly those values.

The priority of test over blank and over the modulator is checked with every off-forcing cause active at once. The modulator's lit-cycle count over a full period is checked at duty 0, 128 and 255. A comparator with the wrong sense, or an off-by-one comparator, shifts those counts by one or inverts them.

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              blank_n,
  input  logic              test_n,
  input  logic              pwm_en,
  input  logic [DUTY_W-1:0] duty,
  input  logic [3:0]        digit,
  output logic [6:0]        seg
);

  logic [3:0]        code_q;
  logic [DUTY_W-1:0] cnt_q;
  logic [6:0]        seg_q;
  logic [6:0]        glyph;

  wire [3:0] code = hold ? code_q : digit;
  wire       dim  = pwm_en && (cnt_q >= duty);
  wire [6:0] seg_d = !test_n ? 7'h7F : (!blank_n || dim) ? 7'h00 : glyph;

  always_comb begin
    case (code)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7C;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h67;
      default: glyph = 7'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      cnt_q  <= '0;
      seg_q  <= '0;
    end else begin
      if (!hold) code_q <= digit;
      cnt_q <= cnt_q + 1'b1;
      seg_q <= seg_d;
    end
  end

  assign seg = seg_q;

endmodule

// File: rtl/seg7_latch_decoder_chk.sv
module seg7_latch_decoder_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hold,
  input logic              blank_n,
  input logic              test_n,
  input logic              pwm_en,
  input logic [DUTY_W-1:0] duty,
  input logic [3:0]        digit,
  input logic [3:0]        code_q,
  input logic [DUTY_W-1:0] cnt_q,
  input logic [6:0]        seg
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (seg == 7'h00 && code_q == 4'd0 && cnt_q == '0)); // R1
  AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (rst)
    (test_n && !hold && digit > 4'd9) |=> seg == 7'h00); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(code_q)); // R6
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    (test_n && !blank_n) |=> seg == 7'h00); // R7
  AST_TEST_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    !test_n |=> seg == 7'h7F); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == DUTY_W'($past(cnt_q) + 1'b1)); // R9
  AST_DUTY_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && duty == '0 && test_n) |=> seg == 7'h00); // R10

endmodule

bind seg7_latch_decoder seg7_latch_decoder_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .blank_n(blank_n), .test_n(test_n),
  .pwm_en(pwm_en), .duty(duty), .digit(digit), .code_q(code_q),
  .cnt_q(cnt_q), .seg(seg)
);

// File: tb/seg7_latch_decoder_tb.sv
module seg7_latch_decoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic       blank_n = 1'b1;
  logic       test_n = 1'b1;
  logic       pwm_en = 1'b0;
  logic [7:0] duty = 8'd0;
  logic [3:0] digit = 4'd0;
  logic [6:0] seg;

  int errors = 0;
  int checks = 0;
  int lit_cnt = 0;

  typedef struct {
    logic [6:0] exp;
    string      req;
    bit         tally;
  } item_t;

  item_t q[$];

  logic [3:0] lat_m = 4'd0;
  logic [7:0] cnt_m = 8'd0;

  always #10 clk = ~clk;

  seg7_latch_decoder u_dut (
    .clk(clk), .rst(rst), .hold(hold), .blank_n(blank_n), .test_n(test_n),
    .pwm_en(pwm_en), .duty(duty), .digit(digit), .seg(seg)
  );

  function automatic logic [6:0] shape(input logic [3:0] c);
    logic [6:0] s;
    case (c)
      4'd0: s = 7'h3F; 4'd1: s = 7'h06; 4'd2: s = 7'h5B; 4'd3: s = 7'h4F;
      4'd4: s = 7'h66; 4'd5: s = 7'h6D; 4'd6: s = 7'h7C; 4'd7: s = 7'h07;
      4'd8: s = 7'h7F; 4'd9: s = 7'h67; default: s = 7'h00;
    endcase
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lat_m <= 4'd0;
      cnt_m <= 8'd0;
    end else begin
      if (!hold) lat_m <= digit;
      cnt_m <= cnt_m + 8'd1;
    end
  end

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.tally && seg != 7'h00) lit_cnt++;
      if (seg !== it.exp) begin
        errors++;
        $display("FAIL %s: seg=%h expected=%h", it.req, seg, it.exp);
      end
    end
  end

  task automatic drive(input logic r, input logic h, input logic b, input logic t,
                       input logic p, input logic [7:0] d, input logic [3:0] g,
                       input string req, input bit tally = 1'b0);
    item_t it;
    logic [3:0] c;
    @(negedge clk);
    rst = r; hold = h; blank_n = b; test_n = t; pwm_en = p; duty = d; digit = g;
    c = h ? lat_m : g;
    if (r) it.exp = 7'h00;
    else if (!t) it.exp = 7'h7F;
    else if (!b || (p && cnt_m >= d)) it.exp = 7'h00;
    else it.exp = shape(c);
    it.req = req;
    it.tally = tally;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic check_lit(input int expv, input string req);
    drain();
    checks++;
    if (lit_cnt != expv) begin
      errors++;
      $display("FAIL %s: lit cycles=%0d expected=%0d", req, lit_cnt, expv);
    end
    lit_cnt = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 1, 0, 8'd0, 4'd9, "R1 reset");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd5, "R1 held code after reset");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd7, "R1 held code after reset");
    for (int i = 0; i < 10; i++)
      drive(0, 0, 1, 1, 0, 8'd0, 4'(i), (i == 6 || i == 9) ? "R3 glyph" : "R2 decode");
    for (int i = 10; i < 16; i++) drive(0, 0, 1, 1, 0, 8'd0, 4'(i), "R4 invalid code");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd1, "R5 pass through");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd8, "R5 pass through");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd12, "R5 pass through");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd3, "R5 pass through");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd7, "R6 hold rising edge");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd8, "R6 digit ignored");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd14, "R6 digit ignored");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd6, "R6 release");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd2, "R6 rehold");
    drive(0, 1, 0, 1, 0, 8'd0, 4'd2, "R7 blank while held");
    drive(0, 0, 0, 1, 0, 8'd0, 4'd8, "R7 blank");
    drive(0, 0, 0, 1, 0, 8'd0, 4'd0, "R7 blank");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd4, "R7 unblank");
    drive(0, 0, 0, 0, 0, 8'd0, 4'd4, "R8 test over blank");
    drive(0, 0, 1, 0, 0, 8'd0, 4'd13, "R8 test over invalid");
    drive(0, 0, 0, 0, 1, 8'd0, 4'd11, "R8 test over all");
    drive(0, 1, 1, 0, 1, 8'd0, 4'd1, "R8 test while held");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd5, "R9 modulator off");
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 1, 1, 8'd128, 4'd8, "R9 duty 128", 1'b1);
    check_lit(128, "R9 duty 128 period");
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 1, 1, 8'd255, 4'd0, "R9 duty 255", 1'b1);
    check_lit(255, "R9 duty 255 period");
    for (int i = 0; i < 256; i++) drive(0, 0, 1, 1, 1, 8'd0, 4'd8, "R10 duty 0", 1'b1);
    check_lit(0, "R10 duty 0 period");
    drive(0, 0, 1, 0, 1, 8'd0, 4'd8, "R10 test over duty 0");
    drive(0, 0, 1, 1, 0, 8'd0, 4'd9, "R9 modulator off again");
    drive(1, 0, 1, 1, 0, 8'd0, 4'd9, "R1 reset again");
    drive(0, 1, 1, 1, 0, 8'd0, 4'd9, "R1 held code after reset");
    drain();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule